// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides whether one memory access may use a page, given the leaf entry that a table walk has already located. It receives the entry, the kind of access (load, store or instruction fetch), whether the processor is running in problem (user) state, a two-bit authority mask, and a flag that says whether the check belongs to the partition-scoped stage of a two-stage translation. It returns the set of permissions the page grants, a fault flag, and a fault cause.

The privilege rules depend on the scope of the check. A process-scoped check on a privileged page refuses every access made from problem state. A partition-scoped check ignores the privileged bit for that purpose. The authority mask narrows read and write rights only for supervisor accesses to non-privileged pages in process scope. When the entry's change bit is clear, the returned permission set loses write, so the page is installed as read-only until its change bit is set. Write-back of reference and change bits is handled elsewhere.

The decision logic is combinational. The result is held in a single output register with valid/ready handshakes on both sides. A request is taken when `in_valid` and `in_ready` are both high. A result stays on the output until `out_ready` is seen high while `out_valid` is high. The input is refused only while a result is held and the consumer is stalling. A stalled output never drops or changes its result.

Top module: `page_perm_checker`

## Requirements
- R1: The access code selects the required permission: 0 needs read, 1 needs write, 2 needs execute, and the reserved code 3 is handled exactly as 0. For a valid entry, a fault is raised if and only if the required permission is missing from the set computed by R3 to R5.
- R2: With default parameters the entry fields are as follows. Bit 63 is valid, bit 3 is privileged and bit 7 is change. Bits 2:0 are the authority field: bit 2 read, bit 1 write, bit 0 execute. `out_grant` uses the same three-bit encoding. All other entry bits have no effect.
- R3: For a process-scoped check (`in_partition`=0) on a privileged page in problem state, no permission is granted and a protection fault is raised for every access code.
- R4: When the access is in problem state, or the page is privileged, or the check is partition-scoped (and R3 does not apply), the permission set equals the authority field, and `in_mask` has no effect.
- R5: For a process-scoped supervisor access to a non-privileged page, the permission set is the authority field ANDed with the mask rights. `in_mask[1]`=1 removes read, `in_mask[0]`=1 removes write, and execute is never affected by the mask.
- R6: When the change bit is clear, write is removed from `out_grant`. The fault decision is made on the set before this removal, so a permitted store to a clean page does not fault.
- R7: An entry with the valid bit clear gives `out_grant`=000, `out_fault`=1 and `out_cause`=01 (no entry). A protection fault gives `out_cause`=10. With no fault, `out_cause`=00.
- R8: The result of an accepted request appears on the outputs with `out_valid`=1 at the clock edge that accepts it. `in_ready` equals `!out_valid || out_ready`, so one request per cycle flows when the consumer never stalls.
- R9: While `out_valid`=1 and `out_ready`=0, all outputs hold their values and `in_ready` is low.
- R10: After reset, `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_pte | input | PTE_W (64) | Leaf page table entry |
| in_access | input | 2 | Access code: 0 read, 1 write, 2 execute, 3 as read |
| in_problem | input | 1 | Access made in problem (user) state |
| in_mask | input | 2 | Authority mask: bit 1 blocks read, bit 0 blocks write |
| in_partition | input | 1 | Check belongs to the partition-scoped stage |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_grant | output | 3 | Granted permissions: bit 2 read, bit 1 write, bit 0 execute |
| out_fault | output | 1 | Access refused |
| out_cause | output | 2 | Fault cause: bit 0 no entry, bit 1 protection |

## Verification
The bench sweeps every combination of the valid, privileged and change bits, the three authority bits, the four access codes, problem state, all mask values and scope, which is 4096 requests. Unrelated entry bits are varied along the way. Each combination falls into exactly one privilege rule: invalid entry, privileged page from problem state, authority alone, or authority masked. The comparison against an arithmetic model therefore separates the mask path from the authority-only path, and shows where scope overrides the privileged bit. Clean-page cases show that the change-bit rule trims the grant but not the fault. A separate stall sequence holds `out_ready` low with a second request waiting. It shows that the held result stays put, that the input is refused, and that the waiting request is taken on the same edge that releases the first.

// File: rtl/perm_pkg.sv
package perm_pkg;

  localparam int PERM_N = 3;
  localparam int PERM_X = 0;
  localparam int PERM_W = 1;
  localparam int PERM_R = 2;

  localparam int MASK_N = 2;
  localparam int MASK_WR = 0;
  localparam int MASK_RD = 1;

  localparam int CAUSE_N = 2;
  localparam int CAUSE_NOENT = 0;
  localparam int CAUSE_PROT = 1;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } access_e;

  typedef struct packed {
    logic [PERM_N-1:0]  grant;
    logic               fault;
    logic [CAUSE_N-1:0] cause;
  } perm_result_t;

  localparam int RES_W = $bits(perm_result_t);

endpackage

// File: rtl/perm_authority.sv
module perm_authority
  import perm_pkg::*;
(
  input  logic [PERM_N-1:0] auth,
  input  logic              priv,
  input  logic              problem,
  input  logic              partition,
  input  logic [MASK_N-1:0] mask,
  output logic [PERM_N-1:0] perms
);

  logic [PERM_N-1:0] mask_allow;
  logic              priv_block;
  logic              auth_only;

  // Rights left by the mask: read and write can be removed, execute never.
  genvar g;
  generate
    for (g = 0; g < PERM_N; g++) begin : g_allow
      if (g == PERM_R) begin : g_rd
        assign mask_allow[g] = ~mask[MASK_RD];
      end else if (g == PERM_W) begin : g_wr
        assign mask_allow[g] = ~mask[MASK_WR];
      end else begin : g_free
        assign mask_allow[g] = 1'b1;
      end
    end
  endgenerate

  always_comb begin
    priv_block = !partition && priv && problem;
    auth_only  = problem || priv || partition;
    if (priv_block) begin
      perms = '0;
    end else if (auth_only) begin
      perms = auth;
    end else begin
      perms = auth & mask_allow;
    end
  end

endmodule

// File: rtl/perm_fault_eval.sv
module perm_fault_eval
  import perm_pkg::*;
(
  input  logic [PERM_N-1:0] perms,
  input  logic [1:0]        access,
  input  logic              entry_valid,
  input  logic              change,
  output perm_result_t      result
);

  access_e           acc;
  logic [PERM_N-1:0] need;
  logic              denied;

  always_comb begin
    acc = access_e'(access);
    unique case (acc)
      ACC_STORE: need = PERM_N'(1) << PERM_W;
      ACC_FETCH: need = PERM_N'(1) << PERM_X;
      default:   need = PERM_N'(1) << PERM_R;
    endcase
  end

  // The fault uses the set before the change-bit trim.
  assign denied = (perms & need) == '0;

  always_comb begin
    result = '0;
    if (!entry_valid) begin
      result.fault              = 1'b1;
      result.cause[CAUSE_NOENT] = 1'b1;
    end else begin
      result.grant = perms;
      if (!change) begin
        result.grant[PERM_W] = 1'b0;
      end
      if (denied) begin
        result.fault             = 1'b1;
        result.cause[CAUSE_PROT] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/perm_out_reg.sv
module perm_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= in_data;
      end
    end
  end

  // R9: a stalled result must neither vanish nor change.
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R8: an accepted request is visible on the next cycle.
  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_data == $past(in_data));

endmodule

// File: rtl/page_perm_checker.sv
module page_perm_checker
  import perm_pkg::*;
#(
  parameter int PTE_W     = 64,
  parameter int VALID_POS = 63,
  parameter int PRIV_POS  = 3,
  parameter int CHG_POS   = 7,
  parameter int AUTH_LSB  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PTE_W-1:0] in_pte,
  input  logic [1:0]       in_access,
  input  logic             in_problem,
  input  logic [1:0]       in_mask,
  input  logic             in_partition,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [2:0]       out_grant,
  output logic             out_fault,
  output logic [1:0]       out_cause
);

  localparam int AUTH_MSB = AUTH_LSB + PERM_N - 1;

  logic [PERM_N-1:0] auth;
  logic [PERM_N-1:0] perms;
  logic              pte_unused;
  perm_result_t      comb_res;
  perm_result_t      held_res;
  logic              fire;

  assign auth       = in_pte[AUTH_MSB:AUTH_LSB];
  assign pte_unused = ^in_pte;
  assign fire       = in_valid && in_ready;

  perm_authority u_authority (
    .auth      (auth),
    .priv      (in_pte[PRIV_POS]),
    .problem   (in_problem),
    .partition (in_partition),
    .mask      (in_mask),
    .perms     (perms)
  );

  perm_fault_eval u_eval (
    .perms       (perms),
    .access      (in_access),
    .entry_valid (in_pte[VALID_POS]),
    .change      (in_pte[CHG_POS]),
    .result      (comb_res)
  );

  perm_out_reg #(.W(RES_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (comb_res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (held_res)
  );

  assign out_grant = held_res.grant;
  assign out_fault = held_res.fault;
  assign out_cause = held_res.cause;

  // R3: privileged page from problem state in process scope grants nothing.
  p_priv_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_pte[VALID_POS] && !in_partition && in_pte[PRIV_POS] && in_problem
    |=> out_grant == '0 && out_fault && out_cause == 2'b10);

  // R4: granted rights never exceed the authority field.
  p_subset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (out_grant & ~$past(auth)) == '0);

  // R5: mask read-block in supervisor process scope on a normal page.
  p_mask_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !in_partition && !in_problem && !in_pte[PRIV_POS] && in_mask[MASK_RD]
    |=> !out_grant[PERM_R]);

  // R6: a clean page is never granted write.
  p_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !in_pte[CHG_POS] |=> !out_grant[PERM_W]);

  // R7: missing entry gives the no-entry cause only.
  p_noent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !in_pte[VALID_POS] |=> out_fault && out_cause == 2'b01 && out_grant == '0);

  // R7: a fault always carries exactly one cause.
  p_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_fault == ($countones(out_cause) == 1) && $onehot0(out_cause));

endmodule

// File: tb/page_perm_checker_tb.sv
module page_perm_checker_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_pte = '0;
  logic [1:0]  in_access = '0;
  logic        in_problem = 1'b0;
  logic [1:0]  in_mask = '0;
  logic        in_partition = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [2:0]  out_grant;
  logic        out_fault;
  logic [1:0]  out_cause;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  page_perm_checker u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pte(in_pte), .in_access(in_access), .in_problem(in_problem),
    .in_mask(in_mask), .in_partition(in_partition), .out_valid(out_valid),
    .out_ready(out_ready), .out_grant(out_grant), .out_fault(out_fault),
    .out_cause(out_cause)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string what, input string got, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %s expected %s", what, got, exp);
    end
  endtask

  // Arithmetic model of R1..R7.
  function automatic logic [5:0] model(input logic v, input logic priv, input logic chg,
                                       input logic [2:0] auth, input logic [1:0] acc,
                                       input logic prob, input logic [1:0] mask,
                                       input logic part);
    logic [2:0] p;
    int         req;
    logic       f;
    if (!v) return {3'b000, 1'b1, 2'b01};
    if (!part && priv && prob) p = 3'b000;
    else if (prob || priv || part) p = auth;
    else p = auth & {~mask[1], ~mask[0], 1'b1};
    req = (acc == 2'd1) ? 1 : (acc == 2'd2) ? 0 : 2;
    f = !p[req];
    if (!chg) p[1] = 1'b0;
    return {p, f, f ? 2'b10 : 2'b00};
  endfunction

  task automatic send(input logic [63:0] pte, input logic [1:0] acc, input logic prob,
                      input logic [1:0] mask, input logic part);
    @(negedge clk);
    in_pte = pte; in_access = acc; in_problem = prob; in_mask = mask;
    in_partition = part; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic [5:0] exp;
    logic [5:0] got;
    logic [63:0] pte;
    logic [5:0] first;
    string tag;
    int n = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check(out_valid == 1'b0 && in_ready == 1'b1, "R10 reset",
          $sformatf("v=%b r=%b", out_valid, in_ready), "v=0 r=1");
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R10 idle after reset", $sformatf("%b", out_valid), "0");

    // Full sweep: R1 R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < 2; v++)
      for (int pr = 0; pr < 2; pr++)
        for (int ch = 0; ch < 2; ch++)
          for (int au = 0; au < 8; au++)
            for (int ac = 0; ac < 4; ac++)
              for (int pb = 0; pb < 2; pb++)
                for (int mk = 0; mk < 4; mk++)
                  for (int pt = 0; pt < 2; pt++) begin
                    pte = '0;
                    pte[40:8] = 33'(n * 32'h9e37_79b1);
                    pte[6:4] = 3'(n >> 2);
                    pte[62:41] = 22'(n * 7);
                    pte[63] = v[0]; pte[3] = pr[0]; pte[7] = ch[0]; pte[2:0] = au[2:0];
                    n++;
                    send(pte, ac[1:0], pb[0], mk[1:0], pt[0]);
                    exp = model(v[0], pr[0], ch[0], au[2:0], ac[1:0], pb[0], mk[1:0], pt[0]);
                    got = {out_grant, out_fault, out_cause};
                    if (!v[0]) tag = "R7";
                    else if (pt == 0 && pr == 1 && pb == 1) tag = "R3";
                    else if (pb == 1 || pr == 1 || pt == 1) tag = "R4";
                    else tag = "R5";
                    if (!ch[0]) tag = {tag, " R6"};
                    check(out_valid && got == exp,
                          $sformatf("%s (R1 R2 R8) v=%0d pr=%0d ch=%0d au=%0d ac=%0d pb=%0d mk=%0d pt=%0d",
                                    tag, v, pr, ch, au, ac, pb, mk, pt),
                          $sformatf("valid=%b g=%b f=%b c=%b", out_valid, got[5:3], got[2], got[1:0]),
                          $sformatf("valid=1 g=%b f=%b c=%b", exp[5:3], exp[2], exp[1:0]));
                  end

    // R9: stall holds the result and refuses the next request
    @(negedge clk);
    out_ready = 1'b0;
    pte = 64'h8000_0000_0000_0086;  // valid, change, read+write
    send(pte, 2'd1, 1'b1, 2'b00, 1'b0);
    first = {out_grant, out_fault, out_cause};
    check(out_valid && first == 6'b110000, "R9 first result",
          $sformatf("%b", first), "110000");
    in_pte = 64'h8000_0000_0000_0001; in_access = 2'd0; in_problem = 1'b1;
    in_mask = 2'b00; in_partition = 1'b0; in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(out_valid && !in_ready && {out_grant, out_fault, out_cause} == first,
            "R9 stall hold", $sformatf("v=%b r=%b d=%b", out_valid, in_ready,
            {out_grant, out_fault, out_cause}), $sformatf("v=1 r=0 d=%b", first));
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    // R8: the waiting request is taken on the releasing edge
    check(out_valid && {out_grant, out_fault, out_cause} == 6'b001110,
          "R8 R9 release", $sformatf("v=%b d=%b", out_valid, {out_grant, out_fault, out_cause}),
          "v=1 d=001110");
    @(negedge clk);
    check(!out_valid && in_ready, "R8 drain", $sformatf("v=%b r=%b", out_valid, in_ready), "v=0 r=1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule